// File: doc/BRIEF.md
# Burst-Mode ADC Conversion Sequencer

This block drives a successive-approximation converter in groups of conversions. A short convert-start pulse from the slow system clock domain crosses into a separate fast burst clock domain. There the sequencer powers the converter up when needed, tracks the input and starts each conversion. It sums the returned samples into a wide accumulator and returns to an idle power state chosen by configuration. In burst mode, one start runs the whole group back to back. In single mode, each start runs one conversion, and the group completes on the last one.

When the group completes, the sum crosses back into the system domain together with a completion toggle. The toggle qualifies the data. On its arrival the result register loads, a sticky end-of-conversion flag sets, and a window-compare hit is evaluated against a lower and an upper threshold. Configuration inputs and thresholds are expected to be static while a group is in progress. Successive starts must be spaced at least four system clock periods apart. The analog core sits outside the block and is reached through a go/done/data handshake.

Top module: `burst_adc_seq`

## Requirements
- R1: The repeat-select code maps 0,1,2,3,4,5 to 1,4,8,16,32,64 conversions, and codes 6 and 7 also mean 64. In burst mode, a single start produces exactly that many `sar_go` pulses and then the sequencer idles.
- R2: In single mode (`cfg_burst_en`=0), each start produces exactly one conversion. `eoc_flag` stays low until the conversion that completes the repeat count.
- R3: `acc_out` is the sum of all samples of the group. It is DW+6 bits wide, so 64 full-scale samples never overflow. The accumulator restarts from zero with each new group.
- R4: `eoc_flag` sets when a completed group arrives in the system domain and holds until `done_clr`. If the arrival and `done_clr` fall in the same system cycle, the set wins.
- R5: `win_hit` is 1 exactly when `win_lo` <= sum <= `win_hi`. Both bounds are inclusive. It is evaluated only when a group completes, and later threshold changes do not alter it.
- R6: In burst mode with `cfg_idle_on`=0, `sar_pwr` falls after each group. With `cfg_idle_on`=1, or in single mode, `sar_pwr` stays high while idle.
- R7: Starting from the powered-down state, `sar_pwr` is high for `cfg_pwrup_cyc`+1 burst cycles before tracking begins. Starting from the enabled idle state, there is no power-up interval.
- R8: Every conversion is preceded by `cfg_track_cyc`+1 burst cycles of `sar_track`. When `cfg_xtrack`=1, 3 further cycles of tracking are added.
- R9: `sar_go` is a one-cycle pulse issued at the end of tracking. A `sar_done` is taken only while a conversion is outstanding, and each one adds exactly one sample.
- R10: A start that arrives while a group is in progress is ignored and does not lengthen or restart the group.
- R11: `acc_out` changes only when a completed group arrives, and stays stable between arrivals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (slow) clock |
| sys_rst_n | input | 1 | Active-low reset, system domain |
| brst_clk | input | 1 | Burst (fast) clock |
| brst_rst_n | input | 1 | Active-low reset, burst domain |
| cfg_burst_en | input | 1 | 1: one start runs the whole group; 0: one start per conversion |
| cfg_idle_on | input | 1 | Burst-mode idle state: 1 stays powered, 0 powers down |
| cfg_rpt_sel | input | 3 | Repeat-count select code |
| cfg_pwrup_cyc | input | PWR_W | Power-up wait, in burst cycles minus one |
| cfg_track_cyc | input | TRK_W | Tracking time, in burst cycles minus one |
| cfg_xtrack | input | 1 | Adds 3 tracking cycles before every conversion |
| win_lo | input | ACC_W | Lower window bound (inclusive) |
| win_hi | input | ACC_W | Upper window bound (inclusive) |
| conv_start | input | 1 | Convert-start pulse, system domain |
| done_clr | input | 1 | Clears `eoc_flag` |
| sar_go | output | 1 | Start-of-conversion pulse to the SAR core |
| sar_pwr | output | 1 | Converter power enable |
| sar_track | output | 1 | Converter tracking phase |
| sar_done | input | 1 | SAR core result valid |
| sar_data | input | DW | SAR core result |
| eoc_flag | output | 1 | Sticky group-complete flag |
| acc_out | output | ACC_W | Accumulated group result |
| win_hit | output | 1 | Window compare result of the last group |

## Verification
The clash that matters is a group's result arriving in the system domain in the same cycle as a software clear of the done flag. The bench holds `done_clr` high through a whole group, so the arrival must meet a clear. It then judges that `eoc_flag` is seen high for exactly one system cycle and that the sum was still captured. A second collision happens in the burst domain: a new start lands while a long group is running. The bench judges it by the exact count of `sar_go` pulses and by the final sum.

// File: rtl/burst_adc_pkg.sv
package burst_adc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PWRUP,
    PH_TRACK,
    PH_XTRK,
    PH_CONV
  } phase_e;

  localparam int MAX_RPT  = 64;
  localparam int RPT_W    = $clog2(MAX_RPT + 1);
  localparam int XTRK_CYC = 3;

  // group length selected by the 3-bit code; unused codes saturate
  function automatic logic [RPT_W-1:0] rpt_of(input logic [2:0] sel);
    case (sel)
      3'd0:    return RPT_W'(1);
      3'd1:    return RPT_W'(4);
      3'd2:    return RPT_W'(8);
      3'd3:    return RPT_W'(16);
      3'd4:    return RPT_W'(32);
      default: return RPT_W'(MAX_RPT);
    endcase
  endfunction

endpackage

// File: rtl/bas_start_sync.sv
module bas_start_sync #(
  parameter int STAGES = 2
) (
  input  logic sys_clk,
  input  logic sys_rst_n,
  input  logic req_pulse,
  input  logic brst_clk,
  input  logic brst_rst_n,
  output logic evt
);

  logic              tgl_q;
  logic [STAGES:0]   sh_q;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n)     tgl_q <= 1'b0;
    else if (req_pulse) tgl_q <= ~tgl_q;
  end

  always_ff @(posedge brst_clk or negedge brst_rst_n) begin
    if (!brst_rst_n) sh_q <= '0;
    else             sh_q <= {sh_q[STAGES-1:0], tgl_q};
  end

  assign evt = sh_q[STAGES] ^ sh_q[STAGES-1];

endmodule

// File: rtl/bas_seq_fsm.sv
module bas_seq_fsm
  import burst_adc_pkg::*;
#(
  parameter int DW    = 10,
  parameter int PWR_W = 4,
  parameter int TRK_W = 4,
  parameter int ACC_W = DW + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             cfg_burst,
  input  logic             cfg_idle_on,
  input  logic [2:0]       cfg_rpt_sel,
  input  logic [PWR_W-1:0] cfg_pwrup,
  input  logic [TRK_W-1:0] cfg_track,
  input  logic             cfg_xtrack,
  input  logic             sar_done,
  input  logic [DW-1:0]    sar_data,
  output logic             sar_go,
  output logic             sar_pwr,
  output logic             sar_track,
  output logic [ACC_W-1:0] acc_q,
  output logic             conv_fin,
  output logic             seq_idle,
  output logic [ACC_W-1:0] res_hold,
  output logic             fin_tgl
);

  localparam int TMR_A = (PWR_W > TRK_W) ? PWR_W : TRK_W;
  localparam int TMR_W = (TMR_A > 2) ? TMR_A : 2;

  phase_e           ph_q, ph_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [RPT_W-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0] acc_d;
  logic             go_d;

  wire              pwr_idle  = !cfg_burst || cfg_idle_on;
  wire              tmr_zero  = (tmr_q == '0);
  wire [RPT_W-1:0]  rpt_n     = rpt_of(cfg_rpt_sel);
  wire [RPT_W-1:0]  cnt_inc   = RPT_W'(cnt_q + 1'b1);
  wire              last_conv = (cnt_inc == rpt_n);
  wire [ACC_W-1:0]  acc_sum   = acc_q + ACC_W'(sar_data);
  wire              took      = (ph_q == PH_CONV) && sar_done;

  always_comb begin
    ph_d  = ph_q;
    tmr_d = tmr_zero ? tmr_q : tmr_q - 1'b1;
    cnt_d = cnt_q;
    acc_d = acc_q;
    go_d  = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start_evt) begin
          if (cnt_q == '0) acc_d = '0;
          if (pwr_idle) begin
            ph_d  = PH_TRACK;
            tmr_d = TMR_W'(cfg_track);
          end else begin
            ph_d  = PH_PWRUP;
            tmr_d = TMR_W'(cfg_pwrup);
          end
        end
      end
      PH_PWRUP: begin
        if (tmr_zero) begin
          ph_d  = PH_TRACK;
          tmr_d = TMR_W'(cfg_track);
        end
      end
      PH_TRACK: begin
        if (tmr_zero) begin
          if (cfg_xtrack) begin
            ph_d  = PH_XTRK;
            tmr_d = TMR_W'(XTRK_CYC - 1);
          end else begin
            ph_d = PH_CONV;
            go_d = 1'b1;
          end
        end
      end
      PH_XTRK: begin
        if (tmr_zero) begin
          ph_d = PH_CONV;
          go_d = 1'b1;
        end
      end
      PH_CONV: begin
        if (sar_done) begin
          acc_d = acc_sum;
          if (last_conv) begin
            cnt_d = '0;
            ph_d  = PH_IDLE;
          end else begin
            cnt_d = cnt_inc;
            if (cfg_burst) begin
              ph_d  = PH_TRACK;
              tmr_d = TMR_W'(cfg_track);
            end else begin
              ph_d = PH_IDLE;
            end
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      tmr_q    <= '0;
      cnt_q    <= '0;
      acc_q    <= '0;
      sar_go   <= 1'b0;
      res_hold <= '0;
      fin_tgl  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      tmr_q  <= tmr_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      sar_go <= go_d;
      if (conv_fin) begin
        res_hold <= acc_sum;
        fin_tgl  <= ~fin_tgl;
      end
    end
  end

  assign conv_fin  = took && last_conv;
  assign seq_idle  = (ph_q == PH_IDLE);
  assign sar_pwr   = !seq_idle || pwr_idle;
  assign sar_track = (ph_q == PH_TRACK) || (ph_q == PH_XTRK);

endmodule

// File: rtl/bas_result_xfer.sv
module bas_result_xfer #(
  parameter int ACC_W  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin_tgl,
  input  logic [ACC_W-1:0] res_hold,
  input  logic [ACC_W-1:0] win_lo,
  input  logic [ACC_W-1:0] win_hi,
  input  logic             done_clr,
  output logic             xfer_evt,
  output logic             eoc_flag,
  output logic [ACC_W-1:0] acc_out,
  output logic             win_hit
);

  function automatic logic in_window(input logic [ACC_W-1:0] v,
                                     input logic [ACC_W-1:0] lo,
                                     input logic [ACC_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], fin_tgl};
  end

  assign xfer_evt = sh_q[STAGES] ^ sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_flag <= 1'b0;
      acc_out  <= '0;
      win_hit  <= 1'b0;
    end else if (xfer_evt) begin
      eoc_flag <= 1'b1;
      acc_out  <= res_hold;
      win_hit  <= in_window(res_hold, win_lo, win_hi);
    end else if (done_clr) begin
      eoc_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_adc_seq.sv
module burst_adc_seq #(
  parameter int DW     = 10,
  parameter int PWR_W  = 4,
  parameter int TRK_W  = 4,
  parameter int SYNC_N = 2,
  localparam int ACC_W = DW + 6
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             brst_clk,
  input  logic             brst_rst_n,
  input  logic             cfg_burst_en,
  input  logic             cfg_idle_on,
  input  logic [2:0]       cfg_rpt_sel,
  input  logic [PWR_W-1:0] cfg_pwrup_cyc,
  input  logic [TRK_W-1:0] cfg_track_cyc,
  input  logic             cfg_xtrack,
  input  logic [ACC_W-1:0] win_lo,
  input  logic [ACC_W-1:0] win_hi,
  input  logic             conv_start,
  input  logic             done_clr,
  output logic             sar_go,
  output logic             sar_pwr,
  output logic             sar_track,
  input  logic             sar_done,
  input  logic [DW-1:0]    sar_data,
  output logic             eoc_flag,
  output logic [ACC_W-1:0] acc_out,
  output logic             win_hit
);

  logic             start_evt;
  logic             conv_fin;
  logic             seq_idle;
  logic [ACC_W-1:0] seq_acc;
  logic [ACC_W-1:0] res_hold;
  logic             fin_tgl;
  logic             xfer_evt;

  bas_start_sync #(.STAGES(SYNC_N)) u_start (
    .sys_clk    (sys_clk),
    .sys_rst_n  (sys_rst_n),
    .req_pulse  (conv_start),
    .brst_clk   (brst_clk),
    .brst_rst_n (brst_rst_n),
    .evt        (start_evt)
  );

  bas_seq_fsm #(.DW(DW), .PWR_W(PWR_W), .TRK_W(TRK_W), .ACC_W(ACC_W)) u_seq (
    .clk         (brst_clk),
    .rst_n       (brst_rst_n),
    .start_evt   (start_evt),
    .cfg_burst   (cfg_burst_en),
    .cfg_idle_on (cfg_idle_on),
    .cfg_rpt_sel (cfg_rpt_sel),
    .cfg_pwrup   (cfg_pwrup_cyc),
    .cfg_track   (cfg_track_cyc),
    .cfg_xtrack  (cfg_xtrack),
    .sar_done    (sar_done),
    .sar_data    (sar_data),
    .sar_go      (sar_go),
    .sar_pwr     (sar_pwr),
    .sar_track   (sar_track),
    .acc_q       (seq_acc),
    .conv_fin    (conv_fin),
    .seq_idle    (seq_idle),
    .res_hold    (res_hold),
    .fin_tgl     (fin_tgl)
  );

  bas_result_xfer #(.ACC_W(ACC_W), .STAGES(SYNC_N)) u_xfer (
    .clk      (sys_clk),
    .rst_n    (sys_rst_n),
    .fin_tgl  (fin_tgl),
    .res_hold (res_hold),
    .win_lo   (win_lo),
    .win_hi   (win_hi),
    .done_clr (done_clr),
    .xfer_evt (xfer_evt),
    .eoc_flag (eoc_flag),
    .acc_out  (acc_out),
    .win_hit  (win_hit)
  );

endmodule

// File: rtl/burst_adc_seq_chk.sv
module burst_adc_seq_chk #(
  parameter int ACC_W = 16
) (
  input logic             brst_clk,
  input logic             brst_rst_n,
  input logic             sys_clk,
  input logic             sys_rst_n,
  input logic             cfg_burst_en,
  input logic             cfg_idle_on,
  input logic             sar_go,
  input logic             sar_pwr,
  input logic             sar_track,
  input logic             sar_done,
  input logic [ACC_W-1:0] seq_acc,
  input logic             conv_fin,
  input logic             seq_idle,
  input logic             done_clr,
  input logic             xfer_evt,
  input logic             eoc_flag,
  input logic [ACC_W-1:0] acc_out
);

  AST_GO_PULSE: assert property (@(posedge brst_clk) disable iff (!brst_rst_n)
    sar_go |=> !sar_go);  // R9

  AST_TRACK_BEFORE_GO: assert property (@(posedge brst_clk) disable iff (!brst_rst_n)
    $rose(sar_go) |-> $past(sar_track));  // R8

  AST_GO_POWERED: assert property (@(posedge brst_clk) disable iff (!brst_rst_n)
    sar_go |-> sar_pwr);  // R7

  AST_NO_OVERFLOW: assert property (@(posedge brst_clk) disable iff (!brst_rst_n)
    (sar_done && !seq_idle) |=> (seq_acc >= $past(seq_acc)));  // R3

  AST_PWR_DOWN_AFTER: assert property (@(posedge brst_clk) disable iff (!brst_rst_n)
    (conv_fin && cfg_burst_en && !cfg_idle_on) |=> !sar_pwr);  // R6

  AST_EOC_SET: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    xfer_evt |=> eoc_flag);  // R4

  AST_EOC_CLEAR: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (done_clr && !xfer_evt) |=> !eoc_flag);  // R4

  AST_ACC_HOLD: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !xfer_evt |=> $stable(acc_out));  // R11

endmodule

bind burst_adc_seq burst_adc_seq_chk #(.ACC_W(ACC_W)) u_chk (
  .brst_clk     (brst_clk),
  .brst_rst_n   (brst_rst_n),
  .sys_clk      (sys_clk),
  .sys_rst_n    (sys_rst_n),
  .cfg_burst_en (cfg_burst_en),
  .cfg_idle_on  (cfg_idle_on),
  .sar_go       (sar_go),
  .sar_pwr      (sar_pwr),
  .sar_track    (sar_track),
  .sar_done     (sar_done),
  .seq_acc      (seq_acc),
  .conv_fin     (conv_fin),
  .seq_idle     (seq_idle),
  .done_clr     (done_clr),
  .xfer_evt     (xfer_evt),
  .eoc_flag     (eoc_flag),
  .acc_out      (acc_out)
);

// File: tb/tb_burst_adc_seq.sv
module tb_burst_adc_seq;

  localparam int DW       = 10;
  localparam int PWR_W    = 4;
  localparam int TRK_W    = 4;
  localparam int ACC_W    = DW + 6;
  localparam int STUB_LAT = 3;
  localparam int PWRUP    = 5;
  localparam int TRACK    = 2;

  logic sys_clk = 1'b0, brst_clk = 1'b0;
  logic sys_rst_n = 1'b0, brst_rst_n = 1'b0;
  logic cfg_burst_en = 1'b1, cfg_idle_on = 1'b0, cfg_xtrack = 1'b0;
  logic [2:0] cfg_rpt_sel = 3'd0;
  logic [PWR_W-1:0] cfg_pwrup_cyc = PWR_W'(PWRUP);
  logic [TRK_W-1:0] cfg_track_cyc = TRK_W'(TRACK);
  logic [ACC_W-1:0] win_lo = '0, win_hi = '1;
  logic conv_start = 1'b0, done_clr = 1'b0;
  logic sar_go, sar_pwr, sar_track;
  logic sar_done = 1'b0;
  logic [DW-1:0] sar_data = '0;
  logic eoc_flag, win_hit;
  logic [ACC_W-1:0] acc_out;

  always #2  brst_clk = ~brst_clk;   // 250 MHz
  always #20 sys_clk  = ~sys_clk;

  burst_adc_seq #(.DW(DW), .PWR_W(PWR_W), .TRK_W(TRK_W)) dut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .brst_clk(brst_clk), .brst_rst_n(brst_rst_n),
    .cfg_burst_en(cfg_burst_en), .cfg_idle_on(cfg_idle_on), .cfg_rpt_sel(cfg_rpt_sel),
    .cfg_pwrup_cyc(cfg_pwrup_cyc), .cfg_track_cyc(cfg_track_cyc), .cfg_xtrack(cfg_xtrack),
    .win_lo(win_lo), .win_hi(win_hi), .conv_start(conv_start), .done_clr(done_clr),
    .sar_go(sar_go), .sar_pwr(sar_pwr), .sar_track(sar_track), .sar_done(sar_done),
    .sar_data(sar_data), .eoc_flag(eoc_flag), .acc_out(acc_out), .win_hit(win_hit)
  );

  int checks = 0, errors = 0;
  int seed = 0;
  bit max_mode = 1'b0;
  int conv_idx = 0, go_cnt = 0, lat_cnt = -1;
  int trk_run = 0, trk_bad = 0, exp_trk = 0;
  int pw_len = 0, pwr_drops = 0;
  bit pw_run = 1'b0, prev_pwr = 1'b0, prev_trk = 1'b0;

  function automatic int smp(int idx);
    if (max_mode) return (1 << DW) - 1;
    return (idx * 173 + seed * 29 + 7) % (1 << DW);
  endfunction

  function automatic int rpt_len(int sel);
    if (sel >= 5) return 64;
    if (sel == 0) return 1;
    return 2 << sel;
  endfunction

  function automatic int exp_sum(int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += smp(i);
    return s;
  endfunction

  // fixed-latency SAR stub and phase monitor, both away from the burst clock's rising edge
  always @(negedge brst_clk) begin
    sar_done = 1'b0;
    if (sar_go) begin
      go_cnt++;
      lat_cnt = STUB_LAT;
    end else if (lat_cnt > 0) begin
      lat_cnt--;
    end
    if (lat_cnt == 0) begin
      sar_done = 1'b1;
      sar_data = DW'(smp(conv_idx));
      conv_idx++;
      lat_cnt = -1;
    end
    if (sar_track) trk_run++;
    else if (prev_trk) begin
      if (trk_run != exp_trk) trk_bad++;
      trk_run = 0;
    end
    if (sar_pwr && !prev_pwr) pw_run = 1'b1;
    if (sar_track && !prev_trk) pw_run = 1'b0;
    if (pw_run && sar_pwr && !sar_track) pw_len++;
    if (!sar_pwr && prev_pwr) pwr_drops++;
    prev_pwr = sar_pwr;
    prev_trk = sar_track;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sys_cyc(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic clear_mon();
    sys_cyc(3);
    go_cnt = 0; conv_idx = 0; trk_bad = 0; pw_len = 0; pw_run = 1'b0; pwr_drops = 0;
  endtask

  task automatic pulse_start();
    @(negedge sys_clk) conv_start = 1'b1;
    @(negedge sys_clk) conv_start = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge sys_clk) done_clr = 1'b1;
    @(negedge sys_clk) done_clr = 1'b0;
  endtask

  task automatic wait_eoc(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge sys_clk);
      if (eoc_flag) seen = 1'b1;
    end
  endtask

  task automatic run_burst(input int sel, input bit idle, input bit xtr);
    bit seen;
    int n = rpt_len(sel);
    @(negedge sys_clk);
    cfg_burst_en = 1'b1; cfg_rpt_sel = 3'(sel); cfg_idle_on = idle; cfg_xtrack = xtr;
    exp_trk = TRACK + 1 + (xtr ? 3 : 0);
    clear_mon();
    pulse_start();
    wait_eoc(seen);
    chk("R4 eoc set after burst", seen, 1);
    chk("R1 conversions per start", go_cnt, n);
    chk("R3 accumulated sum", acc_out, exp_sum(n));
    chk("R8 tracking length", trk_bad, 0);
    if (idle) begin
      chk("R7 no power-up from enabled idle", pw_len, 0);
      chk("R6 power kept after burst", pwr_drops, 0);
      chk("R6 power on in idle", sar_pwr, 1);
    end else begin
      chk("R7 power-up length", pw_len, PWRUP + 1);
      chk("R6 powered down after burst", sar_pwr, 0);
    end
    pulse_clr();
    chk("R4 eoc cleared", eoc_flag, 0);
  endtask

  initial begin
    bit seen;
    int e, hi_cnt;
    sys_cyc(3);
    sys_rst_n = 1'b1; brst_rst_n = 1'b1;
    sys_cyc(1);
    chk("R4 reset eoc", eoc_flag, 0);
    chk("R11 reset acc_out", acc_out, 0);
    chk("R5 reset win_hit", win_hit, 0);
    chk("R9 reset sar_go", sar_go, 0);
    chk("R6 reset powered down", sar_pwr, 0);

    // sweep: every repeat code, both idle states, extra tracking on and off
    for (int sel = 0; sel < 6; sel++)
      for (int idle = 0; idle < 2; idle++)
        for (int xtr = 0; xtr < 2; xtr++) begin
          seed = sel * 4 + idle * 2 + xtr;
          run_burst(sel, idle[0], xtr[0]);
        end

    // code 7 saturates at 64 (R1)
    seed = 30;
    run_burst(7, 1'b0, 1'b0);

    // full-scale samples over 64 conversions (R3)
    max_mode = 1'b1;
    run_burst(5, 1'b1, 1'b0);
    chk("R3 no overflow at full scale", acc_out, 64 * 1023);
    max_mode = 1'b0;

    // window boundaries (R5)
    seed = 11;
    e = exp_sum(8);
    win_lo = ACC_W'(e); win_hi = ACC_W'(e);
    run_burst(2, 1'b1, 1'b0);
    chk("R5 hit at both bounds", win_hit, 1);
    win_lo = ACC_W'(e + 1); win_hi = '1;
    run_burst(2, 1'b1, 1'b0);
    chk("R5 miss below lower bound", win_hit, 0);
    win_lo = '0; win_hi = ACC_W'(e);
    run_burst(2, 1'b1, 1'b0);
    chk("R5 hit at upper bound", win_hit, 1);
    win_lo = ACC_W'(e + 1);
    sys_cyc(20);
    chk("R5 threshold change without completion", win_hit, 1);
    win_lo = '0; win_hi = ACC_W'(e - 1);
    run_burst(2, 1'b1, 1'b0);
    chk("R5 miss above upper bound", win_hit, 0);
    win_hi = '1;

    // single mode, repeat 4 (R2)
    seed = 17;
    @(negedge sys_clk);
    cfg_burst_en = 1'b0; cfg_rpt_sel = 3'd1; cfg_xtrack = 1'b0; cfg_idle_on = 1'b0;
    exp_trk = TRACK + 1;
    clear_mon();
    for (int k = 0; k < 4; k++) begin
      pulse_start();
      sys_cyc(30);
      chk("R2 one conversion per start", go_cnt, k + 1);
      chk("R2 eoc only after last", eoc_flag, (k == 3) ? 1 : 0);
      chk("R6 single mode stays powered", sar_pwr, 1);
    end
    chk("R2 single-mode sum", acc_out, exp_sum(4));
    chk("R8 single-mode tracking", trk_bad, 0);
    pulse_clr();

    // second start while busy is ignored (R10)
    seed = 23;
    @(negedge sys_clk);
    cfg_burst_en = 1'b1; cfg_rpt_sel = 3'd5; cfg_idle_on = 1'b1;
    clear_mon();
    pulse_start();
    sys_cyc(8);
    pulse_start();
    wait_eoc(seen);
    chk("R10 eoc after busy start", seen, 1);
    sys_cyc(100);
    chk("R10 busy start ignored", go_cnt, 64);
    chk("R10 sum unaffected", acc_out, exp_sum(64));
    chk("R4 eoc holds without clear", eoc_flag, 1);
    pulse_clr();

    // completion arriving while clear is held (R4 set wins)
    seed = 5;
    @(negedge sys_clk);
    cfg_rpt_sel = 3'd2;
    clear_mon();
    done_clr = 1'b1;
    pulse_start();
    hi_cnt = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge sys_clk);
      if (eoc_flag) hi_cnt++;
    end
    done_clr = 1'b0;
    chk("R4 set wins over held clear", hi_cnt, 1);
    chk("R11 result captured under clear", acc_out, exp_sum(8));
    sys_cyc(20);
    chk("R11 acc_out stable", acc_out, exp_sum(8));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(600000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule